// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block sits between a load/store unit and the data memory path. For each data access it receives the virtual address, the access size, the direction, the privilege state and the result of a translation-buffer lookup. From these it forms the physical address, decides whether the access is uncacheable, and classifies any fault together with a set of status bits for the trap logic. The translation array and the trap handling sit outside the block.

The checks form a fixed priority chain. Alignment comes first. A physical-mode request comes next and bypasses translation. A malformed virtual address comes after that, then a direct-mapped (superpage) window. For translated accesses the chain continues with a lookup miss, per-mode permission, fault-on-read or fault-on-write, and finally the range of the formed physical address. All results are registered together and qualified by a single strobe one cycle after the request.

Top module: `dtc_xlate_chk`

## Requirements
- R1: While `rst` is high and on the cycle after it, `out_valid`, `out_pa`, `out_uncache`, `out_fault` and `out_status` are all zero.
- R2: A request sampled with `req_valid` high produces `out_valid` high on the following cycle, together with its results. A cycle without a request produces `out_valid` low on the following cycle.
- R3: If `req_va & (2**req_size - 1)` is nonzero, the fault code is 1 (alignment), whatever any other input says. Status bit 0 (write) equals `req_write`.
- R4: With `req_alt` high, `alt_mode` selects the privilege mode used for permission checks. Otherwise `cur_mode` selects it. Mode 0 is kernel, and bit m of each enable mask grants mode m.
- R5: With `req_phys` high and the access aligned, the address is formed without translation or permission checks. The result is VA[39:0], with bits 43:40 all ones if VA bit 40 is set and all zeros otherwise.
- R6: On a translated access whose VA bits 63:47 are not all equal, the fault code is 3 (page fault) and the status sets bit 1 (access violation) and bit 4 (bad address), plus bit 0 for a write.
- R7: An access is direct-mapped when `sp_enable[1]` is set and VA[42:41] is 2, or when VA[47:41] is 7'h7e. It then forms the address as in R5. Outside kernel mode it gives fault code 2 (access violation) with status bit 1 set.
- R8: A lookup miss gives fault code 4. If `req_vpte` is high, it gives fault code 5 instead. In both cases status bit 5 (miss) is set.
- R9: On a hit without faults, the physical address is `{tlb_ppn, VA[12:0]}`.
- R10: A write without the active mode's bit in `tlb_wr_en` gives code 2, with status bits 0 and 1 set and bit 3 copied from `tlb_fonw`. A permitted write with `tlb_fonw` set gives code 3 with status bits 0 and 3.
- R11: A read without the active mode's bit in `tlb_rd_en` gives code 2, with status bit 1 set and bit 2 copied from `tlb_fonr`. A permitted read with `tlb_fonr` set gives code 3 with status bit 2.
- R12: A translated address with any bit at position 44 or above set gives code 6 (machine check).
- R13: When physical bit 39 or bit 43 is set, `out_uncache` is high and address bits 42:35 are cleared.
- R14: When the fault code is nonzero, `out_pa` and `out_uncache` are zero. When it is zero, `out_status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | log2 of access bytes |
| req_write | input | 1 | 1 = store |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode |
| req_vpte | input | 1 | Page-table fetch request |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| sp_enable | input | 2 | Direct-map window enables |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Physical page number |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault on read |
| tlb_fonw | input | 1 | Fault on write |
| out_valid | output | 1 | Results valid |
| out_pa | output | 44 | Physical address |
| out_uncache | output | 1 | Uncacheable access |
| out_fault | output | 3 | Fault code |
| out_status | output | 6 | Fault status bits |

## Verification
Every result of this block is due on the rising edge right after the one that samples the request, because it passes through exactly one register stage. The bench drives each request on a falling edge and drops the strobe one falling edge later. It reads the address, the uncacheable flag, the fault code and the status on that second falling edge, half a period after they were loaded. Back-to-back requests are checked one per cycle to confirm that each result lands in its own cycle. An idle cycle after a request is checked for a low strobe.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ALIGN    = 3'd1,
    FLT_ACV      = 3'd2,
    FLT_PAGE     = 3'd3,
    FLT_MISS     = 3'd4,
    FLT_MISS_PTE = 3'd5,
    FLT_MCHK     = 3'd6
  } dtc_fault_e;

  typedef struct packed {
    logic miss;    // bit 5
    logic bad_va;  // bit 4
    logic fonw;    // bit 3
    logic fonr;    // bit 2
    logic acv;     // bit 1
    logic wr;      // bit 0
  } dtc_stat_t;

  localparam int DIRECT_W   = 40;  // direct-map address width, bit 40 extends upward
  localparam int UNC_LO_BIT = 39;
  localparam int UNC_HI_BIT = 43;
  localparam int CLR_LO_BIT = 35;
  localparam int CLR_HI_BIT = 42;
endpackage

// File: rtl/dtc_mode_sel.sv
module dtc_mode_sel #(
  parameter int MODE_W = 2,
  parameter int NMODE  = 1 << MODE_W
) (
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  input  logic              use_alt,
  input  logic [NMODE-1:0]  rd_mask,
  input  logic [NMODE-1:0]  wr_mask,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              is_kernel
);
  logic [MODE_W-1:0] act_mode;

  always_comb begin
    act_mode  = use_alt ? alt_mode : cur_mode;
    rd_ok     = rd_mask[act_mode];
    wr_ok     = wr_mask[act_mode];
    is_kernel = (act_mode == '0);
  end
endmodule

// File: rtl/dtc_pa_form.sv
module dtc_pa_form
  import dtc_pkg::*;
#(
  parameter int PA_W     = 44,
  parameter int PPN_W    = 32,
  parameter int PG_SHIFT = 13
) (
  input  logic [PA_W-1:0]  va_lo,
  input  logic [PPN_W-1:0] ppn,
  input  logic             use_direct,
  output logic [PA_W-1:0]  pa,
  output logic             uncache,
  output logic             range_err
);
  localparam int FULL_W = PPN_W + PG_SHIFT;
  localparam logic [PA_W-1:0] CLR_MASK =
    PA_W'(((64'd1 << (CLR_HI_BIT - CLR_LO_BIT + 1)) - 64'd1) << CLR_LO_BIT);

  logic [PA_W-1:0] dir_pa;
  logic [PA_W-1:0] tlb_pa;
  logic [PA_W-1:0] sel_pa;

  assign dir_pa = {{(PA_W-DIRECT_W){va_lo[DIRECT_W]}}, va_lo[DIRECT_W-1:0]};

  generate
    if (FULL_W > PA_W) begin : g_wide
      logic [FULL_W-1:0] tlb_full;
      assign tlb_full  = {ppn, va_lo[PG_SHIFT-1:0]};
      assign tlb_pa    = tlb_full[PA_W-1:0];
      assign range_err = |tlb_full[FULL_W-1:PA_W];
    end else begin : g_narrow
      assign tlb_pa    = PA_W'({ppn, va_lo[PG_SHIFT-1:0]});
      assign range_err = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_pa  = use_direct ? dir_pa : tlb_pa;
    uncache = sel_pa[UNC_LO_BIT] | sel_pa[UNC_HI_BIT];
    pa      = uncache ? (sel_pa & ~CLR_MASK) : sel_pa;
  end
endmodule

// File: rtl/dtc_fault_prio.sv
module dtc_fault_prio
  import dtc_pkg::*;
(
  input  logic       misaligned,
  input  logic       phys,
  input  logic       bad_va,
  input  logic       superpage,
  input  logic       is_kernel,
  input  logic       hit,
  input  logic       vpte,
  input  logic       write,
  input  logic       rd_ok,
  input  logic       wr_ok,
  input  logic       fonr,
  input  logic       fonw,
  input  logic       range_err,
  output dtc_fault_e fault,
  output dtc_stat_t  stat,
  output logic       use_direct
);
  always_comb begin
    fault      = FLT_NONE;
    stat       = '0;
    use_direct = 1'b0;
    if (misaligned) begin
      fault = FLT_ALIGN;
    end else if (phys) begin
      use_direct = 1'b1;
    end else if (bad_va) begin
      fault       = FLT_PAGE;
      stat.acv    = 1'b1;
      stat.bad_va = 1'b1;
    end else if (superpage) begin
      use_direct = 1'b1;
      if (!is_kernel) begin
        fault    = FLT_ACV;
        stat.acv = 1'b1;
      end
    end else if (!hit) begin
      fault     = vpte ? FLT_MISS_PTE : FLT_MISS;
      stat.miss = 1'b1;
    end else if (write) begin
      if (!wr_ok) begin
        fault     = FLT_ACV;
        stat.acv  = 1'b1;
        stat.fonw = fonw;
      end else if (fonw) begin
        fault     = FLT_PAGE;
        stat.fonw = 1'b1;
      end
    end else begin
      if (!rd_ok) begin
        fault     = FLT_ACV;
        stat.acv  = 1'b1;
        stat.fonr = fonr;
      end else if (fonr) begin
        fault     = FLT_PAGE;
        stat.fonr = 1'b1;
      end
    end
    if (fault == FLT_NONE && !use_direct && range_err)
      fault = FLT_MCHK;
    if (fault != FLT_NONE)
      stat.wr = write;
  end
endmodule

// File: rtl/dtc_xlate_chk.sv
module dtc_xlate_chk
  import dtc_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int VA_SIG   = 48,
  parameter int PA_W     = 44,
  parameter int PPN_W    = 32,
  parameter int PG_SHIFT = 13,
  parameter int SIZE_W   = 2,
  parameter int MODE_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic                    req_write,
  input  logic                    req_phys,
  input  logic                    req_alt,
  input  logic                    req_vpte,
  input  logic [MODE_W-1:0]       cur_mode,
  input  logic [MODE_W-1:0]       alt_mode,
  input  logic [1:0]              sp_enable,
  input  logic                    tlb_hit,
  input  logic [PPN_W-1:0]        tlb_ppn,
  input  logic [(1<<MODE_W)-1:0]  tlb_rd_en,
  input  logic [(1<<MODE_W)-1:0]  tlb_wr_en,
  input  logic                    tlb_fonr,
  input  logic                    tlb_fonw,
  output logic                    out_valid,
  output logic [PA_W-1:0]         out_pa,
  output logic                    out_uncache,
  output logic [2:0]              out_fault,
  output logic [5:0]              out_status
);
  localparam int ALN_W = (1 << SIZE_W) - 1;

  logic [ALN_W:0]   one_sh;
  logic [ALN_W-1:0] aln_mask;
  logic             misaligned;
  logic             bad_va;
  logic             superpage;
  logic             rd_ok, wr_ok, is_kernel;
  logic             use_direct;
  logic [PA_W-1:0]  pa_c;
  logic             unc_c;
  logic             range_err;
  dtc_fault_e       fault_c;
  dtc_stat_t        stat_c;

  always_comb begin
    one_sh     = (ALN_W+1)'(1) << req_size;
    aln_mask   = ALN_W'(one_sh - (ALN_W+1)'(1));
    misaligned = |(req_va[ALN_W-1:0] & aln_mask);
    bad_va     = !((&req_va[VA_W-1:VA_SIG-1]) || !(|req_va[VA_W-1:VA_SIG-1]));
    superpage  = (sp_enable[1] && req_va[42:41] == 2'b10) || (req_va[47:41] == 7'h7e);
  end

  dtc_mode_sel #(.MODE_W(MODE_W)) u_mode (
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .use_alt  (req_alt),
    .rd_mask  (tlb_rd_en),
    .wr_mask  (tlb_wr_en),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .is_kernel(is_kernel)
  );

  dtc_pa_form #(.PA_W(PA_W), .PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT)) u_pa (
    .va_lo     (req_va[PA_W-1:0]),
    .ppn       (tlb_ppn),
    .use_direct(use_direct),
    .pa        (pa_c),
    .uncache   (unc_c),
    .range_err (range_err)
  );

  dtc_fault_prio u_prio (
    .misaligned(misaligned),
    .phys      (req_phys),
    .bad_va    (bad_va),
    .superpage (superpage),
    .is_kernel (is_kernel),
    .hit       (tlb_hit),
    .vpte      (req_vpte),
    .write     (req_write),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok),
    .fonr      (tlb_fonr),
    .fonw      (tlb_fonw),
    .range_err (range_err),
    .fault     (fault_c),
    .stat      (stat_c),
    .use_direct(use_direct)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_pa      <= '0;
      out_uncache <= 1'b0;
      out_fault   <= '0;
      out_status  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_fault   <= fault_c;
        out_status  <= stat_c;
        out_pa      <= (fault_c == FLT_NONE) ? pa_c : '0;
        out_uncache <= (fault_c == FLT_NONE) && unc_c;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);  // R2
  AST_ALIGN_WINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misaligned) |=> (out_fault == FLT_ALIGN));  // R3
  AST_MISS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_fault == FLT_MISS || out_fault == FLT_MISS_PTE)) |-> out_status[5]);  // R8
  AST_UNC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_uncache) |-> (out_pa[42:35] == 8'h00));  // R13
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault != FLT_NONE) |-> (out_pa == '0 && !out_uncache));  // R14
  AST_CLEAN_NO_STAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault == FLT_NONE) |-> (out_status == '0));  // R14
endmodule

// File: tb/test_dtc_xlate_chk.sv
module test_dtc_xlate_chk;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  rq;
    logic [63:0] va;
    logic [1:0]  sz;
    logic        wr, phys, alt, vpte;
    logic [1:0]  cm, am, sp;
    logic        hit;
    logic [31:0] ppn;
    logic [3:0]  re, we;
    logic        fonr, fonw;
    logic [43:0] epa;
    logic        eunc;
    logic [2:0]  eflt;
    logic [5:0]  est;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{3, 'h1001, 2, 1,0,0,0, 0,0,0, 1,'h55,'hF,'hF,0,0, 'h0,0,1,'h01},                 // R3 write misaligned
    '{3, 'h1003, 1, 0,1,0,0, 0,0,0, 1,'h55,'hF,'hF,0,0, 'h0,0,1,'h00},                 // R3 beats phys
    '{9, 'h4123, 0, 0,0,0,0, 0,0,0, 1,'h55,'h1,'h1,0,0, 'hAA123,0,0,'h00},             // R9 hit
    '{8, 'h6000, 3, 0,0,0,0, 0,0,0, 0,'h0,'hF,'hF,0,0, 'h0,0,4,'h20},                  // R8 normal miss
    '{8, 'h6000, 3, 1,0,0,1, 0,0,0, 0,'h0,'hF,'hF,0,0, 'h0,0,5,'h21},                  // R8 pte miss
    '{10,'h8000, 3, 1,0,0,0, 3,0,0, 1,'h10,'hF,'h7,0,1, 'h0,0,2,'h0B},                 // R10 no wr perm
    '{10,'h8000, 3, 1,0,0,0, 0,0,0, 1,'h10,'hF,'h1,0,1, 'h0,0,3,'h09},                 // R10 fonw
    '{11,'h8000, 3, 0,0,0,0, 1,0,0, 1,'h10,'h1,'hF,1,0, 'h0,0,2,'h06},                 // R11 no rd perm
    '{11,'h8000, 3, 0,0,0,0, 1,0,0, 1,'h10,'h2,'hF,1,0, 'h0,0,3,'h04},                 // R11 fonr
    '{4, 'h2008, 3, 0,0,1,0, 2,0,0, 1,'h1,'h1,'h0,0,0, 'h2008,0,0,'h00},               // R4 alt kernel
    '{4, 'h2008, 3, 0,0,0,0, 0,3,0, 1,'h1,'h1,'h0,0,0, 'h2008,0,0,'h00},               // R4 alt ignored
    '{4, 'h2008, 3, 0,0,1,0, 0,3,0, 1,'h1,'h1,'h0,0,0, 'h0,0,2,'h02},                  // R4 alt user
    '{7, 'hFFFF_FC00_0000_2000, 3, 0,0,0,0, 0,0,0, 0,'h0,'h0,'h0,0,0, 'h2000,0,0,'h00}, // R7 window B
    '{7, 'hFFFF_FC00_0000_2000, 3, 1,0,0,0, 1,0,0, 0,'h0,'h0,'h0,0,0, 'h0,0,2,'h03},    // R7 user acv
    '{7, 'h0400_0000_0000, 3, 0,0,0,0, 0,0,2, 0,'h0,'h0,'h0,0,0, 'h0,0,0,'h00},         // R7 window A
    '{7, 'h0400_0000_0000, 3, 0,0,0,0, 0,0,0, 0,'h0,'h0,'h0,0,0, 'h0,0,4,'h20},         // R7 window A off
    '{13,'hFFFF_FD00_0000_0000, 3, 0,0,0,0, 0,0,0, 0,'h0,'h0,'h0,0,0, 'h800_0000_0000,1,0,'h00}, // R13 sign ext
    '{5, 'h0080_0000_1000, 3, 0,1,0,0, 3,0,0, 0,'h0,'h0,'h0,0,0, 'h1000,1,0,'h00},     // R5 bit39
    '{5, 'hFFFF_FFFF_FFFF_FFF8, 3, 0,1,0,0, 0,0,0, 0,'h0,'h0,'h0,0,0, 'h807_FFFF_FFF8,1,0,'h00}, // R5 ext
    '{5, 'h0212_3456_7000, 3, 0,1,0,0, 0,0,0, 0,'h0,'h0,'h0,0,0, 'h12_3456_7000,0,0,'h00},   // R5 truncate
    '{6, 'h0001_0000_0000_0000, 3, 0,0,0,0, 0,0,0, 1,'h1,'hF,'hF,0,0, 'h0,0,3,'h12},   // R6 read
    '{6, 'h0001_0000_0000_0000, 3, 1,0,0,0, 0,0,0, 1,'h1,'hF,'hF,0,0, 'h0,0,3,'h13},   // R6 write
    '{12,'h0100, 3, 0,0,0,0, 0,0,0, 1,'h8000_0000,'hF,'hF,0,0, 'h0,0,6,'h00},          // R12 read
    '{12,'h0100, 3, 1,0,0,0, 0,0,0, 1,'h8000_0000,'hF,'hF,0,0, 'h0,0,6,'h01},          // R12 write
    '{13,'h0100, 3, 0,0,0,0, 0,0,0, 1,'h0400_0000,'hF,'hF,0,0, 'h100,1,0,'h00},        // R13 bit39
    '{13,'h0010, 3, 0,0,0,0, 0,0,0, 1,'h4000_0000,'hF,'hF,0,0, 'h800_0000_0010,1,0,'h00} // R13 bit43
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_vpte = 1'b0;
  logic [1:0]  cur_mode = '0, alt_mode = '0, sp_enable = '0;
  logic        tlb_hit = 1'b0;
  logic [31:0] tlb_ppn = '0;
  logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
  logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
  logic        out_valid, out_uncache;
  logic [43:0] out_pa;
  logic [2:0]  out_fault;
  logic [5:0]  out_status;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtc_xlate_chk i_dtc_xlate_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
    .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt), .req_vpte(req_vpte),
    .cur_mode(cur_mode), .alt_mode(alt_mode), .sp_enable(sp_enable), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr),
    .tlb_fonw(tlb_fonw), .out_valid(out_valid), .out_pa(out_pa), .out_uncache(out_uncache),
    .out_fault(out_fault), .out_status(out_status)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = 1'b1; req_va = v.va; req_size = v.sz; req_write = v.wr;
    req_phys = v.phys; req_alt = v.alt; req_vpte = v.vpte; cur_mode = v.cm;
    alt_mode = v.am; sp_enable = v.sp; tlb_hit = v.hit; tlb_ppn = v.ppn;
    tlb_rd_en = v.re; tlb_wr_en = v.we; tlb_fonr = v.fonr; tlb_fonw = v.fonw;
  endtask

  task automatic expect_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.rq);
    check(tag, "valid",  64'(out_valid),   64'd1);
    check(tag, "pa",     64'(out_pa),      64'(v.epa));
    check(tag, "unc",    64'(out_uncache), 64'(v.eunc));
    check(tag, "fault",  64'(out_fault),   64'(v.eflt));
    check(tag, "status", 64'(out_status),  64'(v.est));
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    drive(v);
    @(negedge clk);
    req_valid = 1'b0;
    expect_vec(v);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid",  64'(out_valid),   64'd0);
    check("R1", "pa",     64'(out_pa),      64'd0);
    check("R1", "unc",    64'(out_uncache), 64'd0);
    check("R1", "fault",  64'(out_fault),   64'd0);
    check("R1", "status", 64'(out_status),  64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2: idle cycle after a request drops the strobe
    @(negedge clk);
    check("R2", "idle valid", 64'(out_valid), 64'd0);

    // R2: back-to-back requests land one per cycle
    @(negedge clk);
    drive(VEC[2]);
    @(negedge clk);
    drive(VEC[3]);
    check("R2", "first pa", 64'(out_pa), 64'(VEC[2].epa));
    check("R2", "first fault", 64'(out_fault), 64'(VEC[2].eflt));
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", "second valid", 64'(out_valid), 64'd1);
    check("R2", "second fault", 64'(out_fault), 64'(VEC[3].eflt));

    // R14: fault after a clean hit leaves no address
    run_vec(VEC[2]);
    run_vec(VEC[5]);

    // R1: reset mid-run clears a loaded result
    run_vec(VEC[16]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pa after rst",  64'(out_pa),      64'd0);
    check("R1", "unc after rst", 64'(out_uncache), 64'd0);
    check("R1", "valid after rst", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule